// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This core is a small processor built around a single accumulator. Each instruction goes through a fixed series of register transfers. First the fetch steps move the program counter into an address buffer, step the counter, and carry the fetched word through a data buffer into an instruction holding register. A decode step then chooses one of several execute sequences. When execution ends, control goes back to the first fetch step.

All memory traffic uses one single-port synchronous memory with one cycle of read latency. The memory address always comes from the address buffer, and write data always comes from the data buffer. The instruction register and the program counter keep their values while an execute sequence reuses both buffers for its own operand access.

An instruction word has a 4-bit opcode above a 12-bit address or immediate field. A stalling input port supplies data to the accumulator. An output port with a one-cycle valid strobe presents either the accumulator or a memory word.

Top module: `acc_cpu`

## Requirements
- R1: After reset, the program counter, address buffer, accumulator and output register are zero. The first fetch reads address 0, and mem_we and out_valid are low.
- R2: Fetch and decode take 5 cycles. In cycle 1 of an instruction, mem_addr equals the instruction's own address. The program counter then holds that address plus one.
- R3: The instruction word is {opcode[15:12], field[11:0]}. The opcodes are 0 no-op, 1 jump, 2 load immediate, 3 input, 4 load memory, 5 add immediate, 6 add memory, 7 store, 8 output accumulator, and 9 output memory. In memory-referencing instructions, mem_addr equals the field in cycle 6.
- R4: A jump takes 6 cycles, and the next fetch reads the address given in the field.
- R5: Load immediate and add immediate each take 7 cycles. Load immediate sets the accumulator to the field, zero-extended. Add immediate adds the zero-extended field to the accumulator, modulo 2^16.
- R6: The input instruction waits in cycle 5 until in_valid is high and captures in_data in that cycle. It then takes one more cycle to load in_data into the accumulator.
- R7: Load memory and add memory each take 9 cycles. They use the word at the field address. Add memory wraps modulo 2^16.
- R8: A store takes 7 cycles. It asserts mem_we for exactly one cycle, cycle 6, with mem_addr equal to the field and mem_wdata equal to the accumulator. mem_we is low in every other cycle.
- R9: Output accumulator takes 6 cycles and output memory takes 9 cycles. Each pulses out_valid high for one cycle, which is the first cycle of the following instruction. out_data carries the accumulator or the addressed word.
- R10: Opcodes 10 to 15 act as a no-op that takes 5 cycles. A no-op leaves the accumulator unchanged and produces no write and no output.
- R11: An execute sequence changes the program counter only for a jump. It never changes the instruction register, so the next fetch address is correct after operand accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory address, driven from the address buffer |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data, driven from the data buffer |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| in_valid | input | 1 | Input word available |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 16 | Output word |

## Verification
On every cycle, the assertions check the following local rules:
- the program counter steps by one on each fetch;
- the counter stays put outside fetch and jump, and the instruction register stays put outside its load step;
- the accumulator changes only in the final execute step;
- write and output strobes last one cycle, and write data matches the accumulator.

Only the bench's reference model can show the end-to-end results. These are the instruction lengths, the stall on input, the addresses of operand accesses, the accumulator arithmetic including wrap, and that a jump redirects fetch. They also include that a stored word is read back correctly at the top address and that undefined opcodes have no effect.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
    typedef enum logic [3:0] {
        S_FADDR, S_FREAD, S_FLATCH, S_FCIR, S_DECODE,
        S_XADDR, S_XREAD, S_XLATCH, S_XWRITE,
        S_XIMM, S_XIN, S_XJMP, S_XDONE
    } state_e;

    localparam logic [3:0] OP_NOP  = 4'd0;
    localparam logic [3:0] OP_JMP  = 4'd1;
    localparam logic [3:0] OP_LDI  = 4'd2;
    localparam logic [3:0] OP_IN   = 4'd3;
    localparam logic [3:0] OP_LDM  = 4'd4;
    localparam logic [3:0] OP_ADDI = 4'd5;
    localparam logic [3:0] OP_ADDM = 4'd6;
    localparam logic [3:0] OP_STO  = 4'd7;
    localparam logic [3:0] OP_OUTA = 4'd8;
    localparam logic [3:0] OP_OUTM = 4'd9;

    typedef struct packed {
        logic is_jmp;
        logic is_imm;
        logic is_in;
        logic is_mem_rd;
        logic is_sto;
        logic acc_load;
        logic acc_add;
        logic out_acc;
        logic out_mdr;
    } dec_t;
endpackage

// File: rtl/acc_decoder.sv
module acc_decoder
    import acc_cpu_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int ADDR_W = 12,
    localparam int IW    = OP_W + ADDR_W
) (
    input  logic [IW-1:0]     instr,
    output logic [ADDR_W-1:0] field,
    output dec_t              dec
);
    logic [OP_W-1:0] op;

    assign op    = instr[IW-1:ADDR_W];
    assign field = instr[ADDR_W-1:0];

    always_comb begin
        dec = '0;
        case (op)
            OP_JMP:  dec.is_jmp = 1'b1;
            OP_LDI:  begin dec.is_imm = 1'b1; dec.acc_load = 1'b1; end
            OP_IN:   begin dec.is_in = 1'b1; dec.acc_load = 1'b1; end
            OP_LDM:  begin dec.is_mem_rd = 1'b1; dec.acc_load = 1'b1; end
            OP_ADDI: begin dec.is_imm = 1'b1; dec.acc_add = 1'b1; end
            OP_ADDM: begin dec.is_mem_rd = 1'b1; dec.acc_add = 1'b1; end
            OP_STO:  dec.is_sto = 1'b1;
            OP_OUTA: dec.out_acc = 1'b1;
            OP_OUTM: begin dec.is_mem_rd = 1'b1; dec.out_mdr = 1'b1; end
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  logic              add_en,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        if (add_en) result = acc + operand;
        else        result = operand;
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int ADDR_W = 12,
    localparam int DATA_W = OP_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int EXT_W = DATA_W - ADDR_W;

    typedef struct packed {
        state_e            state;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mdr;
        logic [DATA_W-1:0] cir;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] out_data;
        logic              out_valid;
    } regs_t;

    regs_t r_q, r_d;

    logic [ADDR_W-1:0] field;
    dec_t              dec;
    logic [DATA_W-1:0] alu_y;

    acc_decoder #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_dec (
        .instr (r_q.cir),
        .field (field),
        .dec   (dec)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .acc     (r_q.acc),
        .operand (r_q.mdr),
        .add_en  (dec.acc_add),
        .result  (alu_y)
    );

    always_comb begin
        r_d           = r_q;
        r_d.out_valid = 1'b0;
        case (r_q.state)
            S_FADDR: begin
                r_d.mar   = r_q.pc;
                r_d.pc    = r_q.pc + 1'b1;
                r_d.state = S_FREAD;
            end
            S_FREAD:  r_d.state = S_FLATCH;
            S_FLATCH: begin
                r_d.mdr   = mem_rdata;
                r_d.state = S_FCIR;
            end
            S_FCIR: begin
                r_d.cir   = r_q.mdr;
                r_d.state = S_DECODE;
            end
            S_DECODE: begin
                if (dec.is_jmp)                      r_d.state = S_XJMP;
                else if (dec.is_imm)                 r_d.state = S_XIMM;
                else if (dec.is_in)                  r_d.state = S_XIN;
                else if (dec.is_mem_rd || dec.is_sto) r_d.state = S_XADDR;
                else if (dec.out_acc)                r_d.state = S_XDONE;
                else                                 r_d.state = S_FADDR;
            end
            S_XADDR: begin
                r_d.mar = field;
                if (dec.is_sto) begin
                    r_d.mdr   = r_q.acc;
                    r_d.state = S_XWRITE;
                end else begin
                    r_d.state = S_XREAD;
                end
            end
            S_XREAD:  r_d.state = S_XLATCH;
            S_XLATCH: begin
                r_d.mdr   = mem_rdata;
                r_d.state = S_XDONE;
            end
            S_XWRITE: r_d.state = S_FADDR;
            S_XIMM: begin
                r_d.mdr   = {{EXT_W{1'b0}}, field};
                r_d.state = S_XDONE;
            end
            S_XIN: begin
                if (in_valid) begin
                    r_d.mdr   = in_data;
                    r_d.state = S_XDONE;
                end
            end
            S_XJMP: begin
                r_d.pc    = field;
                r_d.state = S_FADDR;
            end
            S_XDONE: begin
                if (dec.acc_load || dec.acc_add) r_d.acc = alu_y;
                if (dec.out_acc) begin
                    r_d.out_valid = 1'b1;
                    r_d.out_data  = r_q.acc;
                end else if (dec.out_mdr) begin
                    r_d.out_valid = 1'b1;
                    r_d.out_data  = r_q.mdr;
                end
                r_d.state = S_FADDR;
            end
            default: r_d.state = S_FADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_FADDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.mar;
    assign mem_we    = (r_q.state == S_XWRITE);
    assign mem_wdata = r_q.mdr;
    assign out_valid = r_q.out_valid;
    assign out_data  = r_q.out_data;

    // Fetch steps the counter by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_FADDR) |=> (r_q.pc == $past(r_q.pc) + 1'b1));

    // Counter held outside fetch and jump
    assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != S_FADDR && r_q.state != S_XJMP) |=> $stable(r_q.pc));

    // Instruction register held outside its load step
    assert_cir_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != S_FCIR) |=> $stable(r_q.cir));

    // Accumulator changes only in the final execute step (R5, R10)
    assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != S_XDONE) |=> $stable(r_q.acc));

    // Write strobe is a single cycle carrying the accumulator
    assert_we_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    assert_we_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == r_q.acc));

    // Output strobe is a single cycle
    assert_out_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    logic [15:0] mem [4096];
    logic [15:0] mm  [4096];

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int tick = 0;

    always #2 clk = ~clk;

    acc_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(int a, logic [3:0] op, logic [11:0] f);
        mem[a] = {op, f};
        mm[a]  = {op, f};
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    function automatic int len_of(logic [3:0] op);
        case (op)
            4'd1, 4'd8:             return 6;
            4'd2, 4'd3, 4'd5, 4'd7: return 7;
            4'd4, 4'd6, 4'd9:       return 9;
            default:                return 5;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd1:       return "R4";
            4'd2, 4'd5: return "R5";
            4'd3:       return "R6";
            4'd4, 4'd6: return "R7";
            4'd7:       return "R8";
            4'd8, 4'd9: return "R9";
            default:    return "R10";
        endcase
    endfunction

    // input stimulus, changes just after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick++;
            in_valid = (tick % 3 == 0);
            in_data  = 16'(tick * 16'h0151 + 7);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            summary();
        end
    end

    // reference model, compared on every clock
    initial begin
        logic [11:0] pc;
        logic [11:0] ipc;
        logic [15:0] acc;
        logic [15:0] ins;
        logic [3:0]  op;
        logic [11:0] f;
        logic [15:0] cap;
        logic        pend;
        logic [15:0] pval;
        string       ptag;
        string       atag;
        int          c;
        int          len;

        for (int i = 0; i < 4096; i++) begin mem[i] = '0; mm[i] = '0; end
        mem[12'h101] = 16'hFFF0; mm[12'h101] = 16'hFFF0;
        mem[12'h102] = 16'hBEEF; mm[12'h102] = 16'hBEEF;
        put(0,  4'd2, 12'h123);
        put(1,  4'd5, 12'h0FF);
        put(2,  4'd8, 12'h000);
        put(3,  4'd7, 12'h100);
        put(4,  4'd6, 12'h100);
        put(5,  4'd8, 12'h000);
        put(6,  4'd4, 12'h101);
        put(7,  4'd5, 12'h020);
        put(8,  4'd8, 12'h000);
        put(9,  4'd9, 12'h102);
        put(10, 4'd3, 12'h000);
        put(11, 4'd8, 12'h000);
        put(12, 4'hF, 12'hABC);
        put(13, 4'hA, 12'h001);
        put(14, 4'd8, 12'h000);
        put(15, 4'd1, 12'h020);
        put(16, 4'd8, 12'h000);
        put(12'h20, 4'd7, 12'hFFF);
        put(12'h21, 4'd9, 12'hFFF);
        put(12'h22, 4'd3, 12'h000);
        put(12'h23, 4'd8, 12'h000);
        put(12'h24, 4'd6, 12'h100);
        put(12'h25, 4'd8, 12'h000);
        put(12'h26, 4'd1, 12'h022);

        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", 32'(out_valid), 0);
        chk("R1 reset mem_we", 32'(mem_we), 0);
        chk("R1 reset mem_addr", 32'(mem_addr), 0);
        rst_n = 1'b1;

        pc = 0; acc = 0; pend = 0; pval = 0; ptag = "R1"; atag = "R1"; cap = 0;
        for (int n = 0; n < 80; n++) begin
            ipc = pc;
            ins = mm[pc];
            op  = ins[15:12];
            f   = ins[11:0];
            pc  = pc + 1'b1;
            len = len_of(op);
            c = 0;
            while (c < len) begin
                if (c == 0) begin
                    chk({"R9 out_valid after ", ptag}, 32'(out_valid), 32'(pend));
                    if (pend) chk({"R9 out_data from ", atag}, 32'(out_data), 32'(pval));
                    pend = 0;
                end else begin
                    chk("R9 out_valid idle", 32'(out_valid), 0);
                end
                if (c == 1)
                    chk({"R2 R11 fetch address after ", ptag}, 32'(mem_addr), 32'(ipc));
                if (op == 4'd7 && c == 6) begin
                    chk("R8 write strobe", 32'(mem_we), 1);
                    chk("R8 write address", 32'(mem_addr), 32'(f));
                    chk("R8 write data", 32'(mem_wdata), 32'(acc));
                end else begin
                    chk({"R8 no write in ", tag_of(op)}, 32'(mem_we), 0);
                end
                if ((op == 4'd4 || op == 4'd6 || op == 4'd9) && c == 6)
                    chk({"R3 operand address ", tag_of(op)}, 32'(mem_addr), 32'(f));
                if (op == 4'd3 && c == 5 && !in_valid) begin
                    c = c;
                end else begin
                    if (op == 4'd3 && c == 5) cap = in_data;
                    c++;
                end
                @(negedge clk);
            end
            case (op)
                4'd1: pc = f;
                4'd2: begin acc = {4'h0, f}; atag = "R5"; end
                4'd3: begin acc = cap; atag = "R6"; end
                4'd4: begin acc = mm[f]; atag = "R7"; end
                4'd5: begin acc = acc + {4'h0, f}; atag = "R5"; end
                4'd6: begin acc = acc + mm[f]; atag = "R7"; end
                4'd7: mm[f] = acc;
                4'd8: begin pend = 1; pval = acc; end
                4'd9: begin pend = 1; pval = mm[f]; end
                default: ;
            endcase
            if (op == 4'd9) atag = "R9";
            ptag = tag_of(op);
        end
        done = 1;
        summary();
    end
endmodule